// File: doc/BRIEF.md
# Address-Wakeup Serial Receiver Control

This block receives asynchronous serial frames from a line sampled at sixteen times the bit rate. It also holds the control byte that a host uses to enable the receiver and the transmitter and to unmask their interrupts. Received bytes go into a data register and set a data-full flag. A zero stop bit raises a framing-error flag. A frame that completes while the previous byte is still unread raises an overrun flag instead of replacing that byte.

For multi-drop links, the host can arm an address filter. While the filter is armed in multiprocessor asynchronous operation, each frame's extra multiprocessor bit is examined. Frames with that bit clear pass on the line and leave no trace in the data register or in any flag. The first frame with the bit set disarms the filter in hardware, and that frame is received like any other. The transmitter datapath is outside this block. Only its two interrupt requests are gated here, and its enable is passed out.

Top module: `mpw_uart_rx`

## Requirements
- R1: After reset the control byte reads 0x00, the status byte reads 0x00, all four interrupt requests are low, and the transmit-allowed output is low.
- R2: The control byte (register select 0) holds transmit interrupt enable at bit 7, receive interrupt enable at bit 6, transmit enable at bit 5, receive enable at bit 4, wakeup arm at bit 3 and transmit-end interrupt enable at bit 2. Bits 1 and 0 read as 0 whatever is written.
- R3: A frame is 1 low start bit, 8 data bits LSB first, then 1 multiprocessor bit only when multiprocessor mode is selected, then 1 stop bit. Each bit is sampled at the middle of its 16 oversampling ticks. On completion the byte appears on the data output and at register select 2, and the data-full flag (status bit 0, register select 1) is set.
- R4: While receive enable is 0, a frame on the line changes neither the data nor the status byte.
- R5: A stop bit sampled as 0 sets the framing-error flag (status bit 1). Writing the status byte with bit 1 at 0 clears that flag and leaves data-full unchanged.
- R6: A frame that completes while data-full is set sets the overrun flag (status bit 2) and keeps the earlier byte. Writing the status byte with bit 2 at 0 clears overrun.
- R7: A read of register select 2 returns the byte and clears data-full.
- R8: While wakeup is armed, multiprocessor mode is selected and the link is asynchronous, a frame whose multiprocessor bit is 0 leaves the data, data-full, framing-error and overrun state unchanged, and the arm bit stays set.
- R9: Under the conditions of R8, a frame whose multiprocessor bit is 1 clears the arm bit and is received normally. This hardware clear wins over a control write in the same cycle.
- R10: With multiprocessor mode off, or with synchronous mode selected, the arm bit has no effect: frames are received and the bit stays set.
- R11: Receive interrupt enable gates both the data-full request and the error request (framing error or overrun).
- R12: The transmit-empty request follows the transmit-empty input only while transmit interrupt enable is 1. The transmit-end request follows the transmit-end input only while transmit-end interrupt enable is 1. Transmit-allowed follows transmit enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| sampleTick | input | 1 | Oversampling tick, 16 per bit |
| mpMode | input | 1 | Multiprocessor frame format selected |
| syncMode | input | 1 | Link is in synchronous mode (disables the wakeup filter) |
| regSel | input | 2 | Register select: 0 control, 1 status, 2 receive data |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| rxData | output | 8 | Last accepted received byte |
| rxFull | output | 1 | Data-full flag |
| frameErr | output | 1 | Framing-error flag |
| overrun | output | 1 | Overrun flag |
| irqRx | output | 1 | Gated receive-data request |
| irqErr | output | 1 | Gated receive-error request |
| irqTx | output | 1 | Gated transmit-empty request |
| irqTxEnd | output | 1 | Gated transmit-end request |
| txEmpty | input | 1 | Transmit buffer empty, from the transmitter |
| txEnd | input | 1 | Transmission finished, from the transmitter |
| txAllowed | output | 1 | Transmit enable passed to the transmitter |

## Verification
A filter stuck armed shows up one frame later. The address frame with its multiprocessor bit set never raises data-full, and the arm bit still reads back as 1. A filter that fails to arm shows up just as quickly: a data frame meant for another node lands in the data register. A wrong bit counter or a sampling point off the middle of the bit corrupts the byte, or moves the multiprocessor bit into the stop position, within the first frame. That shows as a wrong value or a spurious framing error. Flag priorities that are wrong show at the next completed frame: a second unread byte either overwrites the first or fails to raise overrun.

// File: rtl/mpw_rx_pkg.sv
package mpw_rx_pkg;
  localparam int DATA_W = 8;

  // control byte bit positions
  localparam int CTRL_TXIE = 7;
  localparam int CTRL_RXIE = 6;
  localparam int CTRL_TXEN = 5;
  localparam int CTRL_RXEN = 4;
  localparam int CTRL_WAKE = 3;
  localparam int CTRL_TEIE = 2;

  // register selects
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  // control -> datapath strobes
  typedef struct packed {
    logic enable;
    logic mpFrame;
  } rxCtlT;

  // datapath -> control frame result
  typedef struct packed {
    logic              done;
    logic [DATA_W-1:0] data;
    logic              mpBit;
    logic              stopOk;
  } rxFrameT;
endpackage

// File: rtl/mpw_rx_shifter.sv
module mpw_rx_shifter
  import mpw_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxLine,
  input  logic    sampleTick,
  input  rxCtlT   ctl,
  output rxFrameT frame
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 3);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVS / 2 - 2);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS, ST_HOLD} stT;

  stT                st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitIdx;
  logic [DATA_W-1:0] shReg;
  logic              mpReg;
  logic [BW-1:0]     stopIdx;

  assign stopIdx = ctl.mpFrame ? BW'(DATA_W + 1) : BW'(DATA_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_HOLD;
      cnt    <= '0;
      bitIdx <= '0;
      shReg  <= '0;
      mpReg  <= 1'b0;
      frame  <= '0;
    end else begin
      frame.done <= 1'b0;
      if (!ctl.enable) begin
        st  <= ST_HOLD;
        cnt <= '0;
      end else if (sampleTick) begin
        case (st)
          ST_IDLE: if (!rxLine) begin
            st  <= ST_START;
            cnt <= '0;
          end
          ST_START: begin
            if (cnt == MID_CNT) begin
              cnt    <= '0;
              bitIdx <= '0;
              mpReg  <= 1'b0;
              st     <= rxLine ? ST_IDLE : ST_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_BITS: begin
            if (cnt == LAST_CNT) begin
              cnt    <= '0;
              bitIdx <= bitIdx + 1'b1;
              if (bitIdx < BW'(DATA_W)) begin
                shReg <= {rxLine, shReg[DATA_W-1:1]};
              end else if (bitIdx != stopIdx) begin
                mpReg <= rxLine;
              end else begin
                frame.done   <= 1'b1;
                frame.data   <= shReg;
                frame.mpBit  <= mpReg;
                frame.stopOk <= rxLine;
                st           <= ST_HOLD;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: if (rxLine) st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpw_rx_ctrl.sv
module mpw_rx_ctrl
  import mpw_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mpMode,
  input  logic              syncMode,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  input  rxFrameT           frame,
  input  logic              txEmpty,
  input  logic              txEnd,
  output rxCtlT             ctl,
  output logic [7:2]        ctrlBits,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              frameErr,
  output logic              overrun,
  output logic              irqRx,
  output logic              irqErr,
  output logic              irqTx,
  output logic              irqTxEnd,
  output logic              txAllowed
);
  logic wakeActive, dropFrame, acceptFrame, wakeRelease;
  logic wrCtrl, wrStat, rdDataStb;

  assign wakeActive  = ctrlBits[CTRL_WAKE] & mpMode & ~syncMode;
  assign dropFrame   = frame.done & wakeActive & ~frame.mpBit;
  assign acceptFrame = frame.done & ~dropFrame;
  assign wakeRelease = frame.done & wakeActive & frame.mpBit;

  assign wrCtrl    = wrEn && (regSel == SEL_CTRL);
  assign wrStat    = wrEn && (regSel == SEL_STAT);
  assign rdDataStb = rdEn && (regSel == SEL_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= '0;
      rxData   <= '0;
      rxFull   <= 1'b0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlBits <= wrData[7:2];
      if (wakeRelease) ctrlBits[CTRL_WAKE] <= 1'b0;

      if (rdDataStb) rxFull <= 1'b0;
      if (wrStat && !wrData[1]) frameErr <= 1'b0;
      if (wrStat && !wrData[2]) overrun <= 1'b0;

      if (acceptFrame) begin
        if (!frame.stopOk) frameErr <= 1'b1;
        if (rxFull) begin
          overrun <= 1'b1;
        end else begin
          rxFull <= 1'b1;
          rxData <= frame.data;
        end
      end
    end
  end

  assign ctl.enable  = ctrlBits[CTRL_RXEN];
  assign ctl.mpFrame = mpMode;

  assign irqRx     = ctrlBits[CTRL_RXIE] & rxFull;
  assign irqErr    = ctrlBits[CTRL_RXIE] & (frameErr | overrun);
  assign irqTx     = ctrlBits[CTRL_TXIE] & txEmpty;
  assign irqTxEnd  = ctrlBits[CTRL_TEIE] & txEnd;
  assign txAllowed = ctrlBits[CTRL_TXEN];
endmodule

// File: rtl/mpw_uart_rx.sv
module mpw_uart_rx
  import mpw_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       sampleTick,
  input  logic       mpMode,
  input  logic       syncMode,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [7:0] rxData,
  output logic       rxFull,
  output logic       frameErr,
  output logic       overrun,
  output logic       irqRx,
  output logic       irqErr,
  output logic       irqTx,
  output logic       irqTxEnd,
  input  logic       txEmpty,
  input  logic       txEnd,
  output logic       txAllowed
);
  rxCtlT      rxCtl;
  rxFrameT    rxFrame;
  logic [7:2] ctrlBits;

  mpw_rx_shifter #(.OVS(OVS)) u_shift (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .ctl(rxCtl), .frame(rxFrame)
  );

  mpw_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mpMode(mpMode), .syncMode(syncMode),
    .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .frame(rxFrame), .txEmpty(txEmpty), .txEnd(txEnd),
    .ctl(rxCtl), .ctrlBits(ctrlBits), .rxData(rxData), .rxFull(rxFull),
    .frameErr(frameErr), .overrun(overrun), .irqRx(irqRx), .irqErr(irqErr),
    .irqTx(irqTx), .irqTxEnd(irqTxEnd), .txAllowed(txAllowed)
  );

  always_comb begin
    case (regSel)
      SEL_CTRL: rdData = {ctrlBits, 2'b00};
      SEL_STAT: rdData = {5'b0, overrun, frameErr, rxFull};
      SEL_DATA: rdData = rxData;
      default:  rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/mpw_uart_rx_chk.sv
module mpw_uart_rx_chk
  import mpw_rx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       mpMode,
  input logic       syncMode,
  input logic [1:0] regSel,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] rxData,
  input logic       rxFull,
  input logic       frameErr,
  input logic       overrun,
  input logic       irqRx,
  input logic       irqErr,
  input logic       irqTx,
  input logic       irqTxEnd,
  input rxFrameT    rxFrame,
  input logic [7:2] ctrlBits
);
  logic armed;
  assign armed = ctrlBits[CTRL_WAKE] && mpMode && !syncMode;

  assert_drop_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrame.done && armed && !rxFrame.mpBit && !rdEn && !wrEn)
    |=> ($stable(rxFull) && $stable(frameErr) && $stable(overrun) && $stable(rxData)));

  assert_wake_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrame.done && armed && rxFrame.mpBit) |=> !ctrlBits[CTRL_WAKE]);

  assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrame.done && rxFull && !(armed && !rxFrame.mpBit))
    |=> (overrun && $stable(rxData)));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == SEL_DATA && !rxFrame.done) |=> !rxFull);

  assert_rx_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[CTRL_RXEN] |=> !rxFrame.done);

  assert_rx_irq_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (irqRx || irqErr) |-> ctrlBits[CTRL_RXIE]);

  assert_tx_irq_gate_R12: assert property (@(posedge clk) disable iff (!rstN)
    (irqTx |-> ctrlBits[CTRL_TXIE]) and (irqTxEnd |-> ctrlBits[CTRL_TEIE]));
endmodule

bind mpw_uart_rx mpw_uart_rx_chk u_chk (.*);

// File: tb/mpw_uart_rx_bench.sv
`timescale 1ns/1ps
module mpw_uart_rx_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic sampleTick = 1'b1;
  logic mpMode = 1'b0;
  logic syncMode = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, rxData;
  logic rxFull, frameErr, overrun, irqRx, irqErr, irqTx, irqTxEnd, txAllowed;
  logic txEmpty = 1'b0;
  logic txEnd = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mpw_uart_rx u_mpw_uart_rx (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    regSel = sel; rdEn = (sel == 2'd2);
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic driveBit(input logic b);
    @(negedge clk);
    rxLine = b;
    repeat (15) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic mp, input logic stopBit);
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i]);
    if (mpMode) driveBit(mp);
    driveBit(stopBit);
    @(negedge clk);
    rxLine = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic clearAll();
    logic [7:0] v;
    regWrite(2'd1, 8'h00);
    regRead(2'd2, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    txEmpty = 1'b1; txEnd = 1'b1;
    regRead(2'd0, v); check("R1 ctrl", v, 8'h00);
    regRead(2'd1, v); check("R1 status", v, 8'h00);
    check("R1 irqs", {4'b0, irqRx, irqErr, irqTx, irqTxEnd}, 8'h00);
    check("R1 txAllowed", {7'b0, txAllowed}, 8'h00);
    txEmpty = 1'b0; txEnd = 1'b0;
  endtask

  task automatic t_ctrlRw();
    logic [7:0] v;
    regWrite(2'd0, 8'hFF); regRead(2'd0, v); check("R2 all ones", v, 8'hFC);
    regWrite(2'd0, 8'h5B); regRead(2'd0, v); check("R2 pattern", v, 8'h58);
    regWrite(2'd0, 8'h00); regRead(2'd0, v); check("R2 zero", v, 8'h00);
  endtask

  task automatic t_receive();
    logic [7:0] v;
    regWrite(2'd0, 8'h10);
    mpMode = 1'b0;
    sendFrame(8'hA5, 1'b0, 1'b1);
    regRead(2'd1, v); check("R3 plain status", v, 8'h01);
    check("R3 plain data", rxData, 8'hA5);
    regRead(2'd2, v); check("R7 data read", v, 8'hA5);
    regRead(2'd1, v); check("R7 full cleared", v, 8'h00);
    mpMode = 1'b1;
    sendFrame(8'h3C, 1'b0, 1'b1);
    regRead(2'd1, v); check("R3 mp status", v, 8'h01);
    check("R3 mp data", rxData, 8'h3C);
    regRead(2'd2, v);
    mpMode = 1'b0;
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    regWrite(2'd0, 8'h00);
    sendFrame(8'h5A, 1'b0, 1'b1);
    regRead(2'd1, v); check("R4 status", v, 8'h00);
    check("R4 data", rxData, 8'h3C);
    regWrite(2'd0, 8'h10);
  endtask

  task automatic t_frameErr();
    logic [7:0] v;
    sendFrame(8'hC3, 1'b0, 1'b0);
    regRead(2'd1, v); check("R5 set", v, 8'h03);
    regWrite(2'd1, 8'h00);
    regRead(2'd1, v); check("R5 cleared", v, 8'h01);
    regRead(2'd2, v);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    sendFrame(8'h11, 1'b0, 1'b1);
    sendFrame(8'h22, 1'b0, 1'b1);
    regRead(2'd1, v); check("R6 status", v, 8'h05);
    check("R6 kept", rxData, 8'h11);
    regWrite(2'd1, 8'h00);
    regRead(2'd1, v); check("R6 cleared", v, 8'h01);
    regRead(2'd2, v);
  endtask

  task automatic t_wake();
    logic [7:0] v;
    mpMode = 1'b1;
    regWrite(2'd0, 8'h18);
    sendFrame(8'h55, 1'b0, 1'b1);
    regRead(2'd1, v); check("R8 dropped status", v, 8'h00);
    check("R8 data untouched", rxData, 8'h11);
    sendFrame(8'h44, 1'b0, 1'b0);
    regRead(2'd1, v); check("R8 no ferr", v, 8'h00);
    regRead(2'd0, v); check("R8 still armed", v, 8'h18);
    sendFrame(8'h77, 1'b1, 1'b1);
    regRead(2'd1, v); check("R9 status", v, 8'h01);
    check("R9 data", rxData, 8'h77);
    regRead(2'd0, v); check("R9 disarmed", v, 8'h10);
    regRead(2'd2, v);
  endtask

  task automatic t_wakeIgnored();
    logic [7:0] v;
    mpMode = 1'b0;
    regWrite(2'd0, 8'h18);
    sendFrame(8'h66, 1'b0, 1'b1);
    regRead(2'd1, v); check("R10 no mp status", v, 8'h01);
    check("R10 no mp data", rxData, 8'h66);
    regRead(2'd0, v); check("R10 arm kept", v, 8'h18);
    regRead(2'd2, v);
    mpMode = 1'b1; syncMode = 1'b1;
    sendFrame(8'h99, 1'b0, 1'b1);
    regRead(2'd1, v); check("R10 sync status", v, 8'h01);
    check("R10 sync data", rxData, 8'h99);
    regRead(2'd2, v);
    mpMode = 1'b0; syncMode = 1'b0;
    regWrite(2'd0, 8'h10);
  endtask

  task automatic t_rxIrq();
    sendFrame(8'h12, 1'b0, 1'b1);
    check("R11 masked rx", {7'b0, irqRx}, 8'h00);
    regWrite(2'd0, 8'h50);
    check("R11 rx", {7'b0, irqRx}, 8'h01);
    check("R11 no err", {7'b0, irqErr}, 8'h00);
    sendFrame(8'h34, 1'b0, 1'b1);
    check("R11 err", {7'b0, irqErr}, 8'h01);
    regWrite(2'd0, 8'h10);
    check("R11 masked both", {6'b0, irqRx, irqErr}, 8'h00);
    clearAll();
  endtask

  task automatic t_txIrq();
    txEmpty = 1'b1; txEnd = 1'b1;
    regWrite(2'd0, 8'hA4);
    check("R12 enabled", {5'b0, irqTx, irqTxEnd, txAllowed}, 8'h07);
    regWrite(2'd0, 8'h20);
    check("R12 masked", {5'b0, irqTx, irqTxEnd, txAllowed}, 8'h01);
    txEmpty = 1'b0;
    regWrite(2'd0, 8'h80);
    check("R12 no empty", {5'b0, irqTx, irqTxEnd, txAllowed}, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrlRw();
    t_receive();
    t_disabled();
    t_frameErr();
    t_overrun();
    t_wake();
    t_wakeIgnored();
    t_rxIrq();
    t_txIrq();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule